// File: doc/BRIEF.md
# Four-Frame Global Shutter Sequencer

This block produces the digital control waveforms for a global-shutter pixel array in which each pixel carries four independent sub-pixels. A single trigger starts a full acquisition. The array is first held in reset for a fixed number of cycles. Reset is then released and each of the four sub-frames gets its own pair of active-low strobes. The start line falls after a programmed offset and the end line falls after a further programmed width, so that one shot captures four exposures at different moments.

Once the last exposure has closed, the shared reset is pulsed again. Rows are then selected one at a time, and every column of the selected row is converted in parallel. The sequencer moves to the next row only when the readout logic returns a done pulse. After the last row, the array goes back to reset and the block returns to idle with a sticky completion flag.

Offsets and widths are clock-cycle counts that are captured when the trigger is accepted. A zero width is raised to one cycle so that a frame's end never coincides with or precedes its start.

Top module: `gshut_seq`

## Requirements
- R1: While idle (after reset or after a finished sequence), `pix_rst_o` is 1, every bit of `start_n_o` and `end_n_o` is 1, `row_sel_o` is all zero and `busy_o` is 0. A synchronous `rst` returns the block to this state from any point of a sequence and clears `frame_done_o`.
- R2: A trigger sampled while idle raises `busy_o` in the next cycle. `pix_rst_o` then stays 1 for RST_CYC cycles, counting that first busy cycle, before it falls.
- R3: Counting the cycle in which `pix_rst_o` first falls as 0, `start_n_o[k]` falls in cycle ofs[k] and `end_n_o[k]` falls in cycle ofs[k]+w[k]. Here ofs[k] and w[k] are the bytes at bits [8k+7:8k] of `frame_ofs_i` and `frame_wid_i`. Both lines stay low through the second reset and the whole readout.
- R4: A width of 0 is treated as 1. No `end_n_o[k]` is ever low while `start_n_o[k]` is high.
- R5: Offsets and widths are captured in the cycle the trigger is accepted. Changing them later in the sequence does not move any strobe.
- R6: With L the largest ofs[k]+w[k], `pix_rst_o` rises L+1 cycles after it fell and stays 1 for RST_CYC cycles. Row 0 is selected in the next cycle, and `pix_rst_o` is never 1 while a row is selected.
- R7: `row_sel_o` has at most one bit set, and bit r means row r. The selection holds until `rd_done_i` is sampled high and moves to the next row in the following cycle. `rd_done_i` has no effect outside readout.
- R8: After `rd_done_i` on the last row, no row is selected, `pix_rst_o` is 1 and all start and end lines are 1 for RST_CYC cycles. `busy_o` then falls and `frame_done_o` rises, and the flag stays 1 until the next trigger is accepted.
- R9: `busy_o` stays 1 without a gap from the accepted trigger to the end of the final reset. A trigger while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Acquisition trigger, taken only when idle |
| frame_ofs_i | input | N_FRAMES*CNT_W | Start offset per frame, frame k in byte k |
| frame_wid_i | input | N_FRAMES*CNT_W | Exposure width per frame, frame k in byte k |
| rd_done_i | input | 1 | Row conversion finished, one-cycle pulse |
| pix_rst_o | output | 1 | Shared pixel reset, active high |
| start_n_o | output | N_FRAMES | Per-frame start strobe, exposure begins on fall |
| end_n_o | output | N_FRAMES | Per-frame end strobe, exposure ends on fall |
| row_sel_o | output | N_ROWS | One-hot row select for readout |
| busy_o | output | 1 | High for the whole acquisition |
| frame_done_o | output | 1 | Sticky completion flag |

## Verification
A wrong state register or a miscounted phase timer shows at the ports within one cycle. The strobe that falls early or late moves by exactly the error, or reset and row select appear together. A wrong latched offset or width moves a single frame's falling edge while leaving the others in place, so the bench times every edge of every frame against its computed cycle. A faulty row counter shows at once as a skipped, repeated or double select the first time `rd_done_i` is pulsed, or as a row change with no pulse.

// File: rtl/gshut_pkg.sv
package gshut_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_EXPO,
        ST_POST,
        ST_READ,
        ST_FIN
    } seq_st_e;

    typedef struct packed {
        logic in_reset;
        logic expo;
        logic hold;
        logic read;
    } phase_t;

    function automatic phase_t decode_phase(seq_st_e s);
        phase_t p;
        p.in_reset = (s == ST_IDLE) || (s == ST_PRE) || (s == ST_POST) || (s == ST_FIN);
        p.expo     = (s == ST_EXPO);
        p.hold     = (s == ST_POST) || (s == ST_READ);
        p.read     = (s == ST_READ);
        return p;
    endfunction

endpackage

// File: rtl/gshut_strobe.sv
module gshut_strobe #(
    parameter int CNT_W = 8,
    parameter int TW    = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] ofs_i,
    input  logic [CNT_W-1:0] wid_i,
    input  logic             expo_i,
    input  logic             hold_i,
    input  logic [TW-1:0]    timer_i,
    output logic [TW-1:0]    end_t_o,
    output logic             start_n_o,
    output logic             end_n_o
);

    logic [CNT_W-1:0] ofs_q;
    logic [CNT_W-1:0] wid_q;
    logic             start_hit;
    logic             end_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q <= '0;
            wid_q <= CNT_W'(1);
        end else if (load_i) begin
            ofs_q <= ofs_i;
            wid_q <= (wid_i == '0) ? CNT_W'(1) : wid_i;
        end
    end

    assign end_t_o   = TW'(ofs_q) + TW'(wid_q);
    assign start_hit = expo_i && (timer_i >= TW'(ofs_q));
    assign end_hit   = expo_i && (timer_i >= end_t_o);
    assign start_n_o = !(start_hit || hold_i);
    assign end_n_o   = !(end_hit || hold_i);

endmodule

// File: rtl/gshut_rows.sv
module gshut_rows #(
    parameter int N_ROWS = 32,
    parameter int RW     = (N_ROWS > 1) ? $clog2(N_ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic              read_i,
    output logic [N_ROWS-1:0] row_sel_o,
    output logic              last_o
);

    logic [RW-1:0] row_q;

    assign last_o = (row_q == RW'(N_ROWS - 1));

    always_ff @(posedge clk) begin
        if (rst || load_i) begin
            row_q <= '0;
        end else if (adv_i && !last_o) begin
            row_q <= row_q + RW'(1);
        end
    end

    for (genvar r = 0; r < N_ROWS; r++) begin : g_sel
        assign row_sel_o[r] = read_i && (row_q == RW'(r));
    end

endmodule

// File: rtl/gshut_ctrl.sv
module gshut_ctrl
    import gshut_pkg::*;
#(
    parameter int TW      = 9,
    parameter int RST_CYC = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trig_i,
    input  logic          rd_done_i,
    input  logic          row_last_i,
    input  logic [TW-1:0] last_end_i,
    output seq_st_e       st_o,
    output logic [TW-1:0] timer_o,
    output logic          load_o,
    output logic          row_adv_o,
    output logic          busy_o,
    output logic          done_o
);

    localparam logic [TW-1:0] RST_LAST = TW'(RST_CYC - 1);

    seq_st_e       st_q;
    logic [TW-1:0] tmr_q;
    logic          done_q;

    assign load_o    = (st_q == ST_IDLE) && trig_i;
    assign row_adv_o = (st_q == ST_READ) && rd_done_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            tmr_q  <= '0;
            done_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: if (trig_i) begin
                    st_q   <= ST_PRE;
                    tmr_q  <= '0;
                    done_q <= 1'b0;
                end
                ST_PRE: begin
                    if (tmr_q == RST_LAST) begin
                        st_q  <= ST_EXPO;
                        tmr_q <= '0;
                    end else begin
                        tmr_q <= tmr_q + TW'(1);
                    end
                end
                ST_EXPO: begin
                    if (tmr_q >= last_end_i) begin
                        st_q  <= ST_POST;
                        tmr_q <= '0;
                    end else begin
                        tmr_q <= tmr_q + TW'(1);
                    end
                end
                ST_POST: begin
                    if (tmr_q == RST_LAST) begin
                        st_q  <= ST_READ;
                        tmr_q <= '0;
                    end else begin
                        tmr_q <= tmr_q + TW'(1);
                    end
                end
                ST_READ: if (rd_done_i && row_last_i) begin
                    st_q  <= ST_FIN;
                    tmr_q <= '0;
                end
                ST_FIN: begin
                    if (tmr_q == RST_LAST) begin
                        st_q   <= ST_IDLE;
                        tmr_q  <= '0;
                        done_q <= 1'b1;
                    end else begin
                        tmr_q <= tmr_q + TW'(1);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign st_o    = st_q;
    assign timer_o = tmr_q;
    assign busy_o  = (st_q != ST_IDLE);
    assign done_o  = done_q;

endmodule

// File: rtl/gshut_seq.sv
module gshut_seq
    import gshut_pkg::*;
#(
    parameter int N_FRAMES = 4,
    parameter int N_ROWS   = 32,
    parameter int CNT_W    = 8,
    parameter int RST_CYC  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      trig_i,
    input  logic [N_FRAMES*CNT_W-1:0] frame_ofs_i,
    input  logic [N_FRAMES*CNT_W-1:0] frame_wid_i,
    input  logic                      rd_done_i,
    output logic                      pix_rst_o,
    output logic [N_FRAMES-1:0]       start_n_o,
    output logic [N_FRAMES-1:0]       end_n_o,
    output logic [N_ROWS-1:0]         row_sel_o,
    output logic                      busy_o,
    output logic                      frame_done_o
);

    localparam int TW = CNT_W + 1;

    seq_st_e       st;
    phase_t        ph;
    logic [TW-1:0] timer;
    logic [TW-1:0] last_end;
    logic [TW-1:0] end_t [N_FRAMES];
    logic          load;
    logic          row_adv;
    logic          row_last;

    assign ph        = decode_phase(st);
    assign pix_rst_o = ph.in_reset;

    always_comb begin
        last_end = '0;
        for (int k = 0; k < N_FRAMES; k++) begin
            if (end_t[k] > last_end) last_end = end_t[k];
        end
    end

    gshut_ctrl #(.TW(TW), .RST_CYC(RST_CYC)) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .trig_i     (trig_i),
        .rd_done_i  (rd_done_i),
        .row_last_i (row_last),
        .last_end_i (last_end),
        .st_o       (st),
        .timer_o    (timer),
        .load_o     (load),
        .row_adv_o  (row_adv),
        .busy_o     (busy_o),
        .done_o     (frame_done_o)
    );

    for (genvar k = 0; k < N_FRAMES; k++) begin : g_frame
        gshut_strobe #(.CNT_W(CNT_W), .TW(TW)) i_strobe (
            .clk       (clk),
            .rst       (rst),
            .load_i    (load),
            .ofs_i     (frame_ofs_i[k*CNT_W +: CNT_W]),
            .wid_i     (frame_wid_i[k*CNT_W +: CNT_W]),
            .expo_i    (ph.expo),
            .hold_i    (ph.hold),
            .timer_i   (timer),
            .end_t_o   (end_t[k]),
            .start_n_o (start_n_o[k]),
            .end_n_o   (end_n_o[k])
        );
    end

    gshut_rows #(.N_ROWS(N_ROWS)) i_rows (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load),
        .adv_i     (row_adv),
        .read_i    (ph.read),
        .row_sel_o (row_sel_o),
        .last_o    (row_last)
    );

endmodule

// File: rtl/gshut_seq_chk.sv
module gshut_seq_chk #(
    parameter int N_FRAMES = 4,
    parameter int N_ROWS   = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                trig_i,
    input logic                rd_done_i,
    input logic                pix_rst_o,
    input logic [N_FRAMES-1:0] start_n_o,
    input logic [N_FRAMES-1:0] end_n_o,
    input logic [N_ROWS-1:0]   row_sel_o,
    input logic                busy_o,
    input logic                frame_done_o
);

    assert_idle_levels_R1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (pix_rst_o && (&start_n_o) && (&end_n_o) && (row_sel_o == '0)));

    assert_start_in_expo_R3: assert property (@(posedge clk) disable iff (rst)
        (|($past(start_n_o) & ~start_n_o)) |-> !pix_rst_o);

    assert_end_after_start_R4: assert property (@(posedge clk) disable iff (rst)
        ((~end_n_o) & start_n_o) == '0);

    assert_sel_no_reset_R6: assert property (@(posedge clk) disable iff (rst)
        (row_sel_o != '0) |-> !pix_rst_o);

    assert_row_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_sel_o));

    assert_row_hold_R7: assert property (@(posedge clk) disable iff (rst)
        ((row_sel_o != '0) && !rd_done_i) |=> $stable(row_sel_o));

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |-> !busy_o);

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && trig_i) |=> (busy_o || frame_done_o));

endmodule

bind gshut_seq gshut_seq_chk #(.N_FRAMES(N_FRAMES), .N_ROWS(N_ROWS)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .trig_i       (trig_i),
    .rd_done_i    (rd_done_i),
    .pix_rst_o    (pix_rst_o),
    .start_n_o    (start_n_o),
    .end_n_o      (end_n_o),
    .row_sel_o    (row_sel_o),
    .busy_o       (busy_o),
    .frame_done_o (frame_done_o)
);

// File: tb/test_gshut_seq.sv
module test_gshut_seq;

    localparam int NF  = 4;
    localparam int NR  = 32;
    localparam int RST = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig = 1'b0;
    logic [31:0]   ofs_v = '0;
    logic [31:0]   wid_v = '0;
    logic          rd_done = 1'b0;
    logic          pix_rst;
    logic [NF-1:0] start_n;
    logic [NF-1:0] end_n;
    logic [NR-1:0] row_sel;
    logic          busy;
    logic          frame_done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    gshut_seq #(.N_FRAMES(NF), .N_ROWS(NR), .CNT_W(8), .RST_CYC(RST)) i_gshut_seq (
        .clk          (clk),
        .rst          (rst),
        .trig_i       (trig),
        .frame_ofs_i  (ofs_v),
        .frame_wid_i  (wid_v),
        .rd_done_i    (rd_done),
        .pix_rst_o    (pix_rst),
        .start_n_o    (start_n),
        .end_n_o      (end_n),
        .row_sel_o    (row_sel),
        .busy_o       (busy),
        .frame_done_o (frame_done)
    );

    // {offsets frame3..0, widths frame3..0}
    localparam logic [63:0] VEC [4] = '{
        {8'd30,  8'd20,  8'd10,  8'd0,  8'd5,   8'd5,  8'd5,  8'd5},
        {8'd0,   8'd0,   8'd0,   8'd0,  8'd4,   8'd3,  8'd2,  8'd1},
        {8'd1,   8'd50,  8'd3,   8'd7,  8'd0,   8'd2,  8'd9,  8'd0},
        {8'd64,  8'd128, 8'd0,   8'd255, 8'd0,  8'd10, 8'd1,  8'd255}
    };

    task automatic chk_eq(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk_eq({req, " pix_rst"}, pix_rst, 1);
        chk_eq({req, " start_n"}, start_n, 4'hF);
        chk_eq({req, " end_n"}, end_n, 4'hF);
        chk_eq({req, " row_sel"}, row_sel, 0);
        chk_eq({req, " busy"}, busy, 0);
    endtask

    task automatic run_seq(input logic [31:0] ofs, input logic [31:0] wid, input bit disturb);
        int sf [NF];
        int ef [NF];
        int rst_fall = -1;
        int post_rise = -1;
        int b = 0;
        int lmax = 0;
        int gaps = 0;
        string tag;
        tag = disturb ? "R5" : "R3";
        for (int k = 0; k < NF; k++) begin
            sf[k] = -1;
            ef[k] = -1;
        end
        @(negedge clk);
        ofs_v = ofs;
        wid_v = wid;
        trig  = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        chk_eq("R2 busy after trigger", busy, 1);
        chk_eq("R8 done cleared by trigger", frame_done, 0);
        if (disturb) begin
            ofs_v = ~ofs;
            wid_v = ~wid;
            trig  = 1'b1;  // R9: trigger while busy
        end
        while (row_sel == '0 && b < 1200) begin
            if (!busy) gaps++;
            if (rst_fall < 0 && !pix_rst) rst_fall = b;
            if (rst_fall >= 0 && post_rise < 0 && pix_rst) post_rise = b;
            for (int k = 0; k < NF; k++) begin
                if (sf[k] < 0 && !start_n[k]) sf[k] = b;
                if (ef[k] < 0 && !end_n[k]) ef[k] = b;
            end
            @(negedge clk);
            b++;
            trig    = 1'b0;
            rd_done = (b == 1) || (b == RST + 1);  // R7: ignored outside readout
        end
        rd_done = 1'b0;
        for (int k = 0; k < NF; k++) begin
            int ok = ofs[k*8 +: 8];
            int wk = (wid[k*8 +: 8] == 0) ? 1 : int'(wid[k*8 +: 8]);
            if (ok + wk > lmax) lmax = ok + wk;
            chk_eq({tag, " start fall cycle"}, sf[k], RST + ok);
            chk_eq({tag, " R4 end fall cycle"}, ef[k], RST + ok + wk);
        end
        chk_eq("R2 reset release cycle", rst_fall, RST);
        chk_eq("R6 second reset cycle", post_rise, RST + lmax + 1);
        chk_eq("R6 row0 select cycle", b, 2 * RST + lmax + 1);
        chk_eq("R9 busy without gap", gaps, 0);
        chk_eq("R3 strobes held low in readout", {start_n, end_n}, 0);
        for (int r = 0; r < NR; r++) begin
            chk_eq("R7 row select", row_sel, longint'(1) << r);
            repeat (r % 3) @(negedge clk);
            if (r % 3 != 0) chk_eq("R7 row held without done", row_sel, longint'(1) << r);
            rd_done = 1'b1;
            @(negedge clk);
            rd_done = 1'b0;
        end
        chk_eq("R8 no row after last", row_sel, 0);
        chk_eq("R8 final reset", pix_rst, 1);
        chk_eq("R8 strobes high", {start_n, end_n}, 8'hFF);
        chk_eq("R8 still busy", busy, 1);
        b = 1;
        while (busy && b < 50) begin
            @(negedge clk);
            b++;
        end
        chk_eq("R8 final reset length", b - 1, RST);
        chk_eq("R8 done flag", frame_done, 1);
        chk_idle("R1 after sequence");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1 reset state");
        chk_eq("R1 done after reset", frame_done, 0);

        // R7: done pulse in idle has no effect
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
        @(negedge clk);
        chk_idle("R7 done ignored in idle");

        for (int i = 0; i < 4; i++) begin
            run_seq(VEC[i][63:32], VEC[i][31:0], 1'b0);
        end

        repeat (5) @(negedge clk);
        chk_eq("R8 done sticky", frame_done, 1);

        run_seq(VEC[2][63:32], VEC[2][31:0], 1'b1);

        // R1: reset in the middle of exposure
        @(negedge clk);
        ofs_v = {8'd40, 8'd40, 8'd40, 8'd40};
        wid_v = {8'd9, 8'd9, 8'd9, 8'd9};
        trig  = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        repeat (RST + 2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1 reset mid sequence");
        chk_eq("R1 done cleared by reset", frame_done, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule